// File: doc/BRIEF.md
# Serial Clock Configuration Receiver

This block is the device-side configuration port of a programmable clock synthesizer. A host shifts a 24-bit setup word in over three wires: a serial clock, a serial data line and a load strobe. The bits collect in a shift register. A rising strobe copies that register into the active configuration latch. The latch drives the parallel settings of the synthesizer: reference divider, VCO divider, output divider select, second-output function, duty-cycle trim and crystal load-capacitance code.

All serial inputs are brought into the system clock domain through a synchronizer chain, and their edges are detected there. If the strobe is held high while serial clocks arrive, the latch becomes transparent and takes the new shift contents on every serial clock edge. The latch comes out of reset holding a non-zero default word and keeps its contents across power-down.

From the latched word the block derives a bypass indication. It also raises single-cycle warnings when a latch update may glitch the clock outputs and when the VCO divider value is not allowed.

Top module: `serial_cfg_rx`

## Requirements
- R1: On each rising edge of `sclk_i`, the shift register moves one place toward its MSB and takes `data_i` into bit 0. The first bit sent therefore ends up in bit 23. The word bit positions are: cap [23:22], trim [21], clk2 function [20:19], output select [18:16], VCO divider [15:7], reference divider [6:0].
- R2: A rising edge of `strobe_i` copies the shift register to the latch. Serial clock edges that arrive while `strobe_i` is low change none of the latched outputs.
- R3: While `strobe_i` is high, every rising edge of `sclk_i` loads the newly shifted word into the latch, so the outputs follow each bit. Holding the strobe high without serial clocks does not reload the latch.
- R4: After reset the latch holds 0x230406: cap 0, trim 1, clk2 function 0, output select 3, VCO divider 8, reference divider 6.
- R5: `bypass_o` is high exactly when the latched reference divider is 0.
- R6: `bad_vco_o` pulses for one cycle after a latch update whose VCO divider is below 4. It stays low otherwise.
- R7: `glitch_warn_o` pulses for one cycle after a latch update that changes the output select field or the clk2 function field. An update that changes only the dividers, trim or cap fields gives no pulse.
- R8: While `pdts_ni` is low, `outputs_on_o` is low and programming still works. When `pdts_ni` returns high, `outputs_on_o` goes high again and the latched values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| data_i | input | 1 | Serial data |
| strobe_i | input | 1 | Load strobe |
| pdts_ni | input | 1 | Active-low power-down |
| ref_div_o | output | 7 | Latched reference divider |
| vco_div_o | output | 9 | Latched VCO divider |
| out_sel_o | output | 3 | Latched output divider select |
| clk2_fn_o | output | 2 | Latched second-output function |
| duty_trim_o | output | 1 | Latched duty-cycle trim |
| cap_code_o | output | 2 | Latched load-capacitance code |
| bypass_o | output | 1 | Reference divider is zero |
| bad_vco_o | output | 1 | One-cycle illegal VCO divider warning |
| glitch_warn_o | output | 1 | One-cycle output glitch warning |
| outputs_on_o | output | 1 | Clock outputs enabled (not powered down) |

## Verification
The assertions check on every cycle that the shift register takes in the synchronized data bit on each detected serial edge and holds still otherwise. They also check that the latch never changes without a load, and that each warning pulse follows a load in the previous cycle. The illegal-divider pulse is additionally checked against the latched value it reports. Only the bench scenarios can show the complete bit ordering into named fields, the reset default word, per-bit transparency under a held strobe, and which field changes must or must not raise a glitch warning. The same applies to retention of the latch across power-down.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int WORD_W = 24;
  localparam int VCO_MIN = 4;

  typedef struct packed {
    logic [1:0] cap;
    logic       trim;
    logic [1:0] fn2;
    logic [2:0] osel;
    logic [8:0] vco;
    logic [6:0] ref_div;
  } cfg_word_t;

  localparam logic [WORD_W-1:0] DEF_WORD = 24'h230406;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] st [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st[s] <= RST_VAL;
      else if (s == 0) st[s] <= d_i;
      else st[s] <= st[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else prev_q <= st[STAGES-1];
  end

  assign q_o    = st[STAGES-1];
  assign rise_o = st[STAGES-1] & ~prev_q;
endmodule

// File: rtl/scfg_shift.sv
module scfg_shift #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] sr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_o <= '0;
    else if (shift_i) sr_o <= {sr_o[W-2:0], bit_i};
  end

  // R1
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (sr_o[0] == $past(bit_i)) && (sr_o[W-1:1] == $past(sr_o[W-2:0])));
  // R1
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_o));
endmodule

// File: rtl/scfg_latch.sv
module scfg_latch
  import scfg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  cfg_word_t word_i,
  output cfg_word_t word_o,
  output logic      glitch_o,
  output logic      bad_o
);
  logic sel_change;
  assign sel_change = (word_i.osel != word_o.osel) || (word_i.fn2 != word_o.fn2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o   <= cfg_word_t'(DEF_WORD);
      glitch_o <= 1'b0;
      bad_o    <= 1'b0;
    end else begin
      glitch_o <= load_i && sel_change;
      bad_o    <= load_i && (word_i.vco < 9'(VCO_MIN));
      if (load_i) word_o <= word_i;
    end
  end

  // R2
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(word_o));
  // R7
  glitch_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glitch_o |-> $past(load_i));
  // R6
  bad_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |-> $past(load_i) && (word_o.vco < 9'(VCO_MIN)));
endmodule

// File: rtl/serial_cfg_rx.sv
module serial_cfg_rx
  import scfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       data_i,
  input  logic       strobe_i,
  input  logic       pdts_ni,
  output logic [6:0] ref_div_o,
  output logic [8:0] vco_div_o,
  output logic [2:0] out_sel_o,
  output logic [1:0] clk2_fn_o,
  output logic       duty_trim_o,
  output logic [1:0] cap_code_o,
  output logic       bypass_o,
  output logic       bad_vco_o,
  output logic       glitch_warn_o,
  output logic       outputs_on_o
);
  localparam int NIN = 4;
  localparam int I_SCLK = 0, I_DATA = 1, I_STB = 2, I_PD = 3;

  logic [NIN-1:0] in_q, in_rise;
  logic [WORD_W-1:0] sr, sr_next;
  logic sclk_rise, load;
  cfg_word_t load_word, cur;

  scfg_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk_i, .rst_ni,
    .d_i({pdts_ni, strobe_i, data_i, sclk_i}),
    .q_o(in_q), .rise_o(in_rise)
  );

  assign sclk_rise = in_rise[I_SCLK];

  scfg_shift #(.W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .shift_i(sclk_rise), .bit_i(in_q[I_DATA]), .sr_o(sr)
  );

  assign sr_next   = {sr[WORD_W-2:0], in_q[I_DATA]};
  // strobe edge copies; held strobe makes each shift edge a copy too
  assign load      = in_rise[I_STB] || (sclk_rise && in_q[I_STB]);
  assign load_word = cfg_word_t'(sclk_rise ? sr_next : sr);

  scfg_latch u_latch (
    .clk_i, .rst_ni, .load_i(load), .word_i(load_word),
    .word_o(cur), .glitch_o(glitch_warn_o), .bad_o(bad_vco_o)
  );

  assign ref_div_o    = cur.ref_div;
  assign vco_div_o    = cur.vco;
  assign out_sel_o    = cur.osel;
  assign clk2_fn_o    = cur.fn2;
  assign duty_trim_o  = cur.trim;
  assign cap_code_o   = cur.cap;
  assign bypass_o     = (cur.ref_div == '0);
  assign outputs_on_o = in_q[I_PD];

  // R3
  transparent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && in_q[I_STB]) |=> (cur == cfg_word_t'(sr)));
  // R8
  pd_no_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_rise[I_STB] && !in_q[I_PD] && !sclk_rise) |=> (cur == cfg_word_t'(sr)));
endmodule

// File: tb/serial_cfg_rx_test.sv
module serial_cfg_rx_test;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, data = 0, strobe = 0, pdts_n = 1;
  logic [6:0] ref_div; logic [8:0] vco; logic [2:0] osel; logic [1:0] fn2, cap;
  logic trim, bypass, bad, glitch, on;

  int n_tests = 0, n_fail = 0;
  int glitch_cnt = 0, bad_cnt = 0;
  int exp_glitch = 0, exp_bad = 0;
  logic [23:0] m_sr = '0, m_lat = 24'h230406;

  always #2.5 clk = ~clk;

  serial_cfg_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .data_i(data), .strobe_i(strobe),
    .pdts_ni(pdts_n), .ref_div_o(ref_div), .vco_div_o(vco), .out_sel_o(osel),
    .clk2_fn_o(fn2), .duty_trim_o(trim), .cap_code_o(cap), .bypass_o(bypass),
    .bad_vco_o(bad), .glitch_warn_o(glitch), .outputs_on_o(on)
  );

  always @(negedge clk) if (rst_n) begin
    if (glitch) glitch_cnt++;
    if (bad) bad_cnt++;
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic [23:0] out_word();
    return {cap, trim, fn2, osel, vco, ref_div};
  endfunction

  function automatic bit sf_differs(logic [23:0] a, logic [23:0] b);
    return a[20:16] != b[20:16];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_load(logic [23:0] w);
    if (sf_differs(w, m_lat)) exp_glitch++;
    if (w[15:7] < 4) exp_bad++;
    m_lat = w;
  endtask

  task automatic send_bit(logic b);
    data = b; wait_clk(4);
    sclk = 1; wait_clk(4);
    sclk = 0; wait_clk(4);
    m_sr = {m_sr[22:0], b};
    if (strobe) model_load(m_sr);
  endtask

  task automatic send_word(logic [23:0] w);
    for (int i = 23; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_strobe();
    strobe = 1; wait_clk(6);
    model_load(m_sr);
    strobe = 0; wait_clk(6);
  endtask

  task automatic check_all(string req);
    check(req, out_word(), m_lat);
    check({req, " bypass R5"}, bypass, m_lat[6:0] == 0);
    check({req, " glitch count R7"}, glitch_cnt, exp_glitch);
    check({req, " bad count R6"}, bad_cnt, exp_bad);
  endtask

  initial begin
    wait_clk(3);
    check("R4 default word", out_word(), 24'h230406);
    check("R4 fields", {ref_div, vco, osel}, {7'd6, 9'd8, 3'd3});
    rst_n = 1; wait_clk(4);
    check("R4 after release", out_word(), 24'h230406);
    check("R8 outputs on", on, 1);

    // R1 R2: shift without strobe leaves latch alone
    send_word(24'h31_8A_3B);
    check("R2 no load while strobe low", out_word(), 24'h230406);
    pulse_strobe();
    check_all("R1 field order");
    check("R1 ref field", ref_div, 7'd59);
    check("R1 vco field", vco, 9'd276);

    // R5 bypass, R7 no glitch for divider/trim/cap-only change
    send_word({m_lat[23:7] ^ 17'h1_8180, 7'd0});
    pulse_strobe();
    check_all("R5 bypass load");
    check("R5 bypass high", bypass, 1);

    // R6 illegal vco
    send_word({m_lat[23:16], 9'd3, 7'd10});
    pulse_strobe();
    check_all("R6 vco 3");
    send_word({m_lat[23:16], 9'd4, 7'd10});
    pulse_strobe();
    check_all("R6 vco 4 legal");

    // R3 transparent mode, check each bit
    strobe = 1; wait_clk(6);
    model_load(m_sr);
    begin
      logic [23:0] w = 24'hC5_F0_81;
      for (int i = 23; i >= 0; i--) begin
        send_bit(w[i]);
        check("R3 per-bit follow", out_word(), m_lat);
      end
    end
    wait_clk(10);
    check("R3 held strobe no reload", out_word(), m_lat);
    strobe = 0; wait_clk(6);
    check_all("R3 after transparent");

    // R8 power down: programming accepted, values retained
    pdts_n = 0; wait_clk(6);
    check("R8 outputs off", on, 0);
    send_word(24'h0E_44_12);
    pulse_strobe();
    check_all("R8 program while down");
    pdts_n = 1; wait_clk(6);
    check("R8 outputs back on", on, 1);
    check_all("R8 retained");

    // random words
    void'($urandom(32'h5EED_0307));
    for (int k = 0; k < 30; k++) begin
      logic [23:0] w = 24'($urandom());
      if (k % 5 == 0) w[15:7] = 9'($urandom_range(0, 3));
      if (k % 7 == 0) w[6:0] = '0;
      if (k % 3 == 0) w[20:16] = m_lat[20:16];
      send_word(w);
      check("R2 random no early load", out_word(), m_lat);
      pulse_strobe();
      check_all("R1 R7 random load");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule